// File: doc/BRIEF.md
# Dual-Digit Multiplexed Hex Display Driver

This block shows two 4-bit values as hex characters on a pair of common-anode seven-segment digits. The two digits share one set of segment lines, and the block has a single hex-to-glyph decoder. A refresh clock is divided down from the system clock. Its level, held in a two-state machine, selects which value feeds the decoder and which digit's anode enable is active. At the default ratio, a 48 MHz clock gives a 60 Hz refresh clock, which is fast enough that the eye sees both digits lit steadily.

The refresh machine has two states. `PH_FIRST` is the low level of the refresh clock: the low value is decoded and the first digit is enabled. `PH_SECOND` is the high level: the high value is decoded and the second digit is enabled. There are three transitions. `PH_FIRST` goes to `PH_SECOND` when the divider reaches its terminal count. `PH_SECOND` goes back to `PH_FIRST` at the next terminal count. Reset forces `PH_FIRST` from either state. Separately, the binary sum of the two values drives five LED outputs, and two spare LED outputs are held at a fixed level so that they never float.

Top module: `hexmux_display`

## Requirements
- R1: Each refresh phase lasts exactly HALF_PERIOD clock cycles (default 400,000), and the phase changes on the clock edge that ends that count.
- R2: In phase `PH_FIRST`, seg_n carries the glyph of val_lo, an_lo_n is 0 and an_hi_n is 1.
- R3: In phase `PH_SECOND`, seg_n carries the glyph of val_hi, an_hi_n is 0 and an_lo_n is 1.
- R4: Exactly one of an_lo_n and an_hi_n is low in every cycle, including during reset.
- R5: seg_n is active low, with bit 0 as segment a through bit 6 as segment g. The active-high glyph codes for 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex), and seg_n is the bitwise inverse of the code.
- R6: sum_led equals val_lo + val_hi as an unsigned 5-bit value (0 to 30), and follows the inputs combinationally.
- R7: spare_led is held at 2'b00 in every cycle.
- R8: A synchronous, active-high reset clears the divider and selects `PH_FIRST`. After reset is released, that first phase lasts a full HALF_PERIOD cycles.
- R9: The decode is combinational. A change of the selected value updates seg_n within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| val_lo | input | 4 | Value shown on the first digit |
| val_hi | input | 4 | Value shown on the second digit |
| seg_n | output | 7 | Shared segment lines, active low, bit 0 = a |
| an_lo_n | output | 1 | First digit anode enable, active low |
| an_hi_n | output | 1 | Second digit anode enable, active low |
| sum_led | output | 5 | Binary sum of the two values |
| spare_led | output | 2 | Unused LEDs, held low |

## Verification
The assertions assume that val_lo and val_hi change only between clock edges. They also assume that reset is held high from time zero until at least one clock edge has passed, so that the phase-length counter in the checker starts aligned with the divider. The bench drives every input on the falling edge and asserts reset before the first rising edge. Its value changes between samples mark the one deliberate case in which seg_n moves while the anodes hold. The divider ratio is set to 5 so that many complete phases fit in a short run.

// File: rtl/hexmux_pkg.sv
package hexmux_pkg;
    localparam int NIB_W   = 4;
    localparam int SEG_W   = 7;
    localparam int SUM_W   = NIB_W + 1;
    localparam int DIGITS  = 2;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;
endpackage

// File: rtl/refresh_fsm.sv
module refresh_fsm
    import hexmux_pkg::*;
#(
    parameter int HALF_PERIOD = 400000
) (
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);
    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

    phase_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q,   cnt_d;
    logic             term;

    assign term = (cnt_q == LAST);

    // state and divider registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FIRST;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = term ? '0 : cnt_q + CNT_W'(1);
        unique case (state_q)
            PH_FIRST:  if (term) state_d = PH_SECOND;
            PH_SECOND: if (term) state_d = PH_FIRST;
            default:   state_d = PH_FIRST;
        endcase
    end

    // outputs
    always_comb begin
        phase = state_q;
    end
endmodule

// File: rtl/hex_glyph.sv
module hex_glyph
    import hexmux_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic [NIB_W-1:0] nib,
    output logic [SEG_W-1:0] seg
);
    logic [SEG_W-1:0] lit;   // 1 = segment on, bit 0 = a

    always_comb begin
        unique case (nib)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            4'hF: lit = 7'h71;
            default: lit = '0;
        endcase
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign seg = ~lit;
        end else begin : g_high
            assign seg = lit;
        end
    endgenerate
endmodule

// File: rtl/nibble_sum.sv
module nibble_sum #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   s
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_fa
            assign s[i]       = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
    endgenerate

    assign s[W] = carry[W];
endmodule

// File: rtl/hexmux_display.sv
module hexmux_display
    import hexmux_pkg::*;
#(
    parameter int   HALF_PERIOD = 400000,
    parameter int   SPARE_N     = 2,
    parameter logic SPARE_LEVEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NIB_W-1:0]   val_lo,
    input  logic [NIB_W-1:0]   val_hi,
    output logic [SEG_W-1:0]   seg_n,
    output logic               an_lo_n,
    output logic               an_hi_n,
    output logic [SUM_W-1:0]   sum_led,
    output logic [SPARE_N-1:0] spare_led
);
    phase_e           phase;
    logic [NIB_W-1:0] shown;
    logic [DIGITS-1:0] an_vec_n;

    refresh_fsm #(.HALF_PERIOD(HALF_PERIOD)) u_refresh (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    // nibble steering follows the phase level
    always_comb begin
        unique case (phase)
            PH_FIRST:  shown = val_lo;
            PH_SECOND: shown = val_hi;
            default:   shown = val_lo;
        endcase
    end

    hex_glyph #(.ACTIVE_LOW(1'b1)) u_glyph (
        .nib (shown),
        .seg (seg_n)
    );

    // one active-low anode enable per digit
    generate
        for (genvar d = 0; d < DIGITS; d++) begin : g_anode
            assign an_vec_n[d] = (phase != phase_e'(d));
        end
    endgenerate

    assign an_lo_n = an_vec_n[0];
    assign an_hi_n = an_vec_n[1];

    nibble_sum #(.W(NIB_W)) u_sum (
        .a (val_lo),
        .b (val_hi),
        .s (sum_led)
    );

    assign spare_led = {SPARE_N{SPARE_LEVEL}};
endmodule

// File: rtl/hexmux_checker.sv
module hexmux_checker #(
    parameter int   HALF_PERIOD = 400000,
    parameter int   SPARE_N     = 2,
    parameter logic SPARE_LEVEL = 1'b0
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         val_lo,
    input logic [3:0]         val_hi,
    input logic [6:0]         seg_n,
    input logic               an_lo_n,
    input logic               an_hi_n,
    input logic [4:0]         sum_led,
    input logic [SPARE_N-1:0] spare_led
);
    localparam int CW = $clog2(HALF_PERIOD + 2) + 1;

    logic          prev_an;
    logic [CW-1:0] run_len;

    // samples seen in the current phase, counted independently of the divider
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_an <= 1'b0;
            run_len <= '0;
        end else begin
            prev_an <= an_lo_n;
            run_len <= (an_lo_n != prev_an) ? CW'(1) : run_len + CW'(1);
        end
    end

    AST_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
        (an_lo_n != prev_an) |-> (run_len == CW'(HALF_PERIOD))); // R1
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_len <= CW'(HALF_PERIOD)); // R1
    AST_ONE_ANODE: assert property (@(posedge clk)
        $countones({an_lo_n, an_hi_n}) == 1); // R4
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
        sum_led == ({1'b0, val_lo} + {1'b0, val_hi})); // R6
    AST_SPARE_QUIET: assert property (@(posedge clk)
        spare_led == {SPARE_N{SPARE_LEVEL}}); // R7
    AST_RESET_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!an_lo_n && an_hi_n)); // R8
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(an_lo_n) && $stable(val_lo) && $stable(val_hi)) |-> $stable(seg_n)); // R9
endmodule

bind hexmux_display hexmux_checker #(
    .HALF_PERIOD (HALF_PERIOD),
    .SPARE_N     (SPARE_N),
    .SPARE_LEVEL (SPARE_LEVEL)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .val_lo    (val_lo),
    .val_hi    (val_hi),
    .seg_n     (seg_n),
    .an_lo_n   (an_lo_n),
    .an_hi_n   (an_hi_n),
    .sum_led   (sum_led),
    .spare_led (spare_led)
);

// File: tb/hexmux_display_tb.sv
module hexmux_display_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;
    localparam int WATCHDOG   = 20000;

    // active-high glyph codes, bit 0 = segment a
    localparam logic [6:0] GLY [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
    };

    // {val_hi, val_lo, expected sum}
    localparam logic [12:0] VEC [10] = '{
        {4'h0, 4'h0, 5'h00}, {4'hF, 4'hF, 5'h1E}, {4'h0, 4'hF, 5'h0F},
        {4'hF, 4'h0, 5'h0F}, {4'h5, 4'hA, 5'h0F}, {4'hA, 4'h6, 5'h10},
        {4'h8, 4'h1, 5'h09}, {4'h3, 4'h4, 5'h07}, {4'h9, 4'hB, 5'h14},
        {4'h7, 4'hE, 5'h15}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] val_lo = 4'h0;
    logic [3:0] val_hi = 4'h0;
    logic [6:0] seg_n;
    logic       an_lo_n, an_hi_n;
    logic [4:0] sum_led;
    logic [1:0] spare_led;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    hexmux_display #(.HALF_PERIOD(HALF)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .val_lo    (val_lo),
        .val_hi    (val_hi),
        .seg_n     (seg_n),
        .an_lo_n   (an_lo_n),
        .an_hi_n   (an_hi_n),
        .sum_led   (sum_led),
        .spare_led (spare_led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_phase(input bit first);
        @(negedge clk);
        while (an_lo_n != !first) @(negedge clk);
    endtask

    task automatic check_shown(input bit first, input logic [3:0] v, input string req);
        chk(seg_n == ~GLY[v], req, seg_n, ~GLY[v]);
        chk(an_lo_n == !first && an_hi_n == first, req, {an_lo_n, an_hi_n}, {!first, first});
    endtask

    // count samples per phase right after a reset release
    task automatic measure_runs(input int runs, input string req);
        int  len = 1;
        bit  cur = an_lo_n;
        int  done = 0;
        while (done < runs) begin
            @(negedge clk);
            chk($countones({an_lo_n, an_hi_n}) == 1, "R4", {an_lo_n, an_hi_n}, 1);
            if (an_lo_n == cur) len++;
            else begin
                chk(len == HALF, req, len, HALF);
                cur  = an_lo_n;
                len  = 1;
                done++;
            end
        end
    endtask

    initial begin
        // reset state R8/R4/R7
        repeat (3) @(negedge clk);
        chk(an_lo_n == 1'b0 && an_hi_n == 1'b1, "R8", {an_lo_n, an_hi_n}, 2'b01);
        chk(spare_led == 2'b00, "R7", spare_led, 0);
        rst = 1'b0;
        chk(an_lo_n == 1'b0, "R8", an_lo_n, 0);
        measure_runs(6, "R1");

        // vector table: both phases and the sum
        for (int i = 0; i < 10; i++) begin
            val_hi = VEC[i][12:9];
            val_lo = VEC[i][8:5];
            #1;
            chk(sum_led == VEC[i][4:0], "R6", sum_led, VEC[i][4:0]);
            wait_phase(1'b1);
            check_shown(1'b1, VEC[i][8:5], "R2");
            wait_phase(1'b0);
            check_shown(1'b0, VEC[i][12:9], "R3");
            chk(spare_led == 2'b00, "R7", spare_led, 0);
        end

        // all 16 glyphs on both digits R5
        for (int v = 0; v < 16; v++) begin
            val_lo = 4'(v);
            val_hi = 4'(15 - v);
            wait_phase(1'b1);
            check_shown(1'b1, 4'(v), "R5");
            wait_phase(1'b0);
            check_shown(1'b0, 4'(15 - v), "R5");
        end

        // all 256 sums R6
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk);
                val_lo = 4'(a);
                val_hi = 4'(b);
                #1;
                chk(sum_led == 5'(a + b), "R6", sum_led, a + b);
            end
        end

        // combinational update without a clock edge R9
        wait_phase(1'b1);
        val_lo = 4'h2;
        #1;
        chk(seg_n == ~GLY[2], "R9", seg_n, ~GLY[2]);
        val_lo = 4'hD;
        #1;
        chk(seg_n == ~GLY[13], "R9", seg_n, ~GLY[13]);
        val_hi = 4'h4;
        #1;
        chk(seg_n == ~GLY[13], "R9 unselected", seg_n, ~GLY[13]);

        // reset in the second phase R8
        wait_phase(1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk(an_lo_n == 1'b0 && an_hi_n == 1'b1, "R8", {an_lo_n, an_hi_n}, 2'b01);
        repeat (HALF + 2) @(negedge clk);
        chk(an_lo_n == 1'b0, "R8 held", an_lo_n, 0);
        rst = 1'b0;
        measure_runs(2, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule